// File: doc/BRIEF.md
# Serial Shadow-RAM Memory Slave

This block is the slave side of a small serial memory. It holds sixteen 16-bit words of working RAM, and every bit has a nonvolatile copy. Here that copy is modelled as a second register array. A host selects the slave with a chip-enable, toggles a serial clock and shifts bits in on a data input. The slave returns read data on a data output that it drives only while it is answering a read.

Each transfer begins with an instruction byte, sent most significant bit first. The byte is a start bit, a 4-bit word address and a 3-bit opcode. The opcodes cover these operations:
- set or clear a write-enable latch;
- copy the whole RAM into the shadow array;
- copy the shadow array back into RAM;
- write one word;
- read one word.

Word data moves least significant bit first. A 4-bit bit pointer walks through the word and wraps around, and the word address never advances. The serial pins are sampled with the block's system clock, and the slave acts on the edges of the chip-enable-gated serial clock.

Top module: `shadow_ram_serial`

## Requirements
- R1: After reset both arrays hold zero, the write-enable latch is clear and `dout_oe` is low.
- R2: While the slave waits for an instruction, `din` samples of 0 at gated-clock rising edges are skipped, and the first 1 is taken as the start bit.
- R3: The seven bits after the start bit are the word address (4 bits) and then the opcode (3 bits), both MSB first. The opcode codes are: 000 clear write-enable, 001 store, 010 reserved, 011 write word, 100 set write-enable, 101 recall, and 110 or 111 read word.
- R4: Write word and store change the arrays only while the write-enable latch is set. The latch is set by opcode 100 and cleared by opcode 000.
- R5: After a write-word instruction, each further rising edge stores `din` into the addressed word at the bit pointer. The pointer starts at 0 and counts to 15. It then wraps to 0, so later bits overwrite the same word from bit 0.
- R6: For a read, `dout_oe` rises and `dout` shows bit 0 after the falling gated-clock edge that follows the last instruction bit. Each later rising edge advances the pointer, and the next falling edge presents that bit, wrapping after bit 15.
- R7: Store (001) copies all of RAM into the shadow array at once. Recall (101) copies the whole shadow array into RAM.
- R8: The reserved opcode 010 leaves both arrays and the latch unchanged.
- R9: The gated clock is `ce & sk`. A rise of `ce` while `sk` is high counts as a rising edge and samples `din`.
- R10: While `ce` is low, the instruction decoder and the bit pointer return to their idle state and `dout_oe` goes low. `dout_oe` is high only during a read.
- R11: After a single-byte instruction, further clocks are ignored until `ce` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Chip-enable, high while selected |
| sk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data in |
| dout | output | 1 | Serial data out, valid while `dout_oe` is high |
| dout_oe | output | 1 | Output drive enable; low means high impedance |

## Verification
The assertions assume that `ce`, `sk` and `din` are synchronous to `clk` and that each level is held for at least one clock. Under that assumption every serial edge is seen exactly once, and `din` is stable at the rising gated edge. The stimulus changes the pins one nanosecond after a clock edge and holds each level for two clocks. The stimulus also starts instructions both with `sk` low and with `sk` already high. It raises `ce` to start, and drops `ce` partway through both writes and reads.

// File: rtl/shadow_ram_serial.sv
module shadow_ram_serial #(
  parameter int WORDS = 16,
  parameter int WIDTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic sk,
  input  logic din,
  output logic dout,
  output logic dout_oe
);
  localparam int AW    = $clog2(WORDS);
  localparam int PW    = $clog2(WIDTH);
  localparam int IBITS = AW + 3;
  localparam int CW    = $clog2(IBITS + 1);

  localparam logic [2:0] OP_WDIS  = 3'b000;
  localparam logic [2:0] OP_STORE = 3'b001;
  localparam logic [2:0] OP_RSVD  = 3'b010;
  localparam logic [2:0] OP_WRITE = 3'b011;
  localparam logic [2:0] OP_WEN   = 3'b100;
  localparam logic [2:0] OP_RCL   = 3'b101;

  typedef enum logic [2:0] {S_IDLE, S_INSTR, S_WR, S_RD, S_DONE} st_t;

  st_t                          st;
  logic                         gsk_q;
  logic [CW-1:0]                cnt;
  logic [IBITS-1:0]             ins;
  logic [AW-1:0]                wsel;
  logic [PW-1:0]                ptr;
  logic                         wel;
  logic [WORDS-1:0][WIDTH-1:0]  ram;
  logic [WORDS-1:0][WIDTH-1:0]  shadow;

  wire              gsk    = ce & sk;
  wire              rise   = gsk & ~gsk_q;
  wire              fall   = ce & ~sk & gsk_q;
  wire [IBITS-1:0]  ins_nx = {ins[IBITS-2:0], din};
  wire              last   = (cnt == CW'(IBITS - 1));
  wire [2:0]        op     = ins_nx[2:0];
  wire [PW-1:0]     ptr_nx = (ptr == PW'(WIDTH - 1)) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      gsk_q   <= 1'b0;
      cnt     <= '0;
      ins     <= '0;
      wsel    <= '0;
      ptr     <= '0;
      wel     <= 1'b0;
      ram     <= '0;
      shadow  <= '0;
      dout    <= 1'b0;
      dout_oe <= 1'b0;
    end else begin
      gsk_q <= gsk;
      if (!ce) begin
        st      <= S_IDLE;
        cnt     <= '0;
        ptr     <= '0;
        dout_oe <= 1'b0;
        dout    <= 1'b0;
      end else if (rise) begin
        case (st)
          S_IDLE: if (din) begin
            st  <= S_INSTR;
            cnt <= '0;
          end
          S_INSTR: begin
            ins <= ins_nx;
            cnt <= cnt + 1'b1;
            if (last) begin
              wsel <= ins_nx[IBITS-1:3];
              ptr  <= '0;
              st   <= S_DONE;
              case (op)
                OP_WDIS:  wel <= 1'b0;
                OP_STORE: if (wel) shadow <= ram;
                OP_RSVD:  ;
                OP_WRITE: st <= S_WR;
                OP_WEN:   wel <= 1'b1;
                OP_RCL:   ram <= shadow;
                default:  st <= S_RD;
              endcase
            end
          end
          S_WR: begin
            if (wel) ram[wsel][ptr] <= din;
            ptr <= ptr_nx;
          end
          S_RD: ptr <= ptr_nx;
          default: ;
        endcase
      end else if (fall && st == S_RD) begin
        dout_oe <= 1'b1;
        dout    <= ram[wsel][ptr];
      end
    end
  end

  AST_CE_LOW_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> (!dout_oe && st == S_IDLE));  // R10
  AST_OE_STARTS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> ($past(ce) && !$past(sk)));  // R6
  AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && !wel) |=> $stable(ram));  // R4
  AST_STORE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !wel |=> $stable(shadow));  // R4
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && (st == S_WR || st == S_RD) && ptr == PW'(WIDTH - 1)) |=> ptr == '0);  // R5
  AST_LEADING_ZERO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && rise && !din) |=> st == S_IDLE);  // R2
  AST_DONE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE && ce) |=> (st == S_DONE && $stable(ram) && $stable(shadow) && $stable(wel)));  // R11
endmodule

// File: tb/test_shadow_ram_serial.sv
module test_shadow_ram_serial;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0, sk = 1'b0, din = 1'b0;
  logic dout, dout_oe;
  int compared = 0, mismatched = 0;

  always #(CLK_P/2) clk = ~clk;

  shadow_ram_serial i_shadow_ram_serial (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sk(sk), .din(din),
    .dout(dout), .dout_oe(dout_oe));

  // behavioural reference: 0 idle, 1 instruction, 2 write, 3 read, 4 done
  int mram[16], mshd[16];
  int m_st, m_n, m_v, m_a, m_p;
  bit m_wel, m_oe, m_d, m_prev;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mram[k]) begin mram[k] = 0; mshd[k] = 0; end
      m_st = 0; m_wel = 0; m_oe = 0; m_d = 0; m_prev = 0; m_p = 0;
    end else begin
      bit g;
      g = ce && sk;
      if (!ce) begin
        m_st = 0; m_oe = 0; m_d = 0; m_p = 0;
      end else if (g && !m_prev) begin
        if (m_st == 0) begin
          if (din) begin m_st = 1; m_n = 0; m_v = 0; end
        end else if (m_st == 1) begin
          m_v = m_v * 2 + int'(din);
          m_n++;
          if (m_n == 7) begin
            m_a = m_v / 8; m_p = 0; m_st = 4;
            case (m_v % 8)
              0: m_wel = 0;
              1: if (m_wel) foreach (mram[k]) mshd[k] = mram[k];
              3: m_st = 2;
              4: m_wel = 1;
              5: foreach (mram[k]) mram[k] = mshd[k];
              6, 7: m_st = 3;
              default: ;
            endcase
          end
        end else if (m_st == 2) begin
          if (m_wel) begin
            if (din) mram[m_a] = mram[m_a] | (1 << m_p);
            else     mram[m_a] = mram[m_a] & ~(1 << m_p);
          end
          m_p = (m_p + 1) % 16;
        end else if (m_st == 3) begin
          m_p = (m_p + 1) % 16;
        end
      end else if (!g && m_prev && m_st == 3) begin
        m_oe = 1; m_d = bit'((mram[m_a] >> m_p) & 1);
      end
      m_prev = g;
    end
  end

  always @(negedge clk) if (rst_n) begin
    compared++;
    if (dout_oe !== m_oe) begin
      mismatched++;
      $display("FAIL R10 per-clock dout_oe: actual %b expected %b at %0t", dout_oe, m_oe, $time);
    end else if (m_oe && dout !== m_d) begin
      mismatched++;
      $display("FAIL R6 per-clock dout: actual %b expected %b at %0t", dout, m_d, $time);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input logic b);
    din = b; sk = 1'b0; step();
    sk = 1'b1; step();
  endtask

  task automatic instr(input bit via_ce, input int lead, input logic [3:0] a, input logic [2:0] op);
    if (via_ce) begin
      sk = 1'b1; din = 1'b1; step();
      ce = 1'b1; step();
    end else begin
      sk = 1'b0; ce = 1'b1; step();
      for (int i = 0; i < lead; i++) send_bit(1'b0);
      send_bit(1'b1);
    end
    for (int i = 3; i >= 0; i--) send_bit(a[i]);
    for (int i = 2; i >= 0; i--) send_bit(op[i]);
  endtask

  task automatic finish_xfer();
    ce = 1'b0; sk = 1'b0; din = 1'b0; step();
  endtask

  task automatic one_byte(input bit via_ce, input int lead, input logic [2:0] op);
    instr(via_ce, lead, 4'd0, op);
    finish_xfer();
  endtask

  task automatic write_word(input bit via_ce, input logic [3:0] a, input logic [31:0] pat, input int n);
    instr(via_ce, 0, a, 3'b011);
    for (int i = 0; i < n; i++) send_bit(pat[i]);
    finish_xfer();
  endtask

  task automatic read_word(input bit via_ce, input logic [3:0] a, input logic [2:0] op,
                           input int n, output logic [15:0] w);
    w = '0;
    instr(via_ce, 0, a, op);
    din = 1'b0; sk = 1'b0; step();
    for (int i = 0; i < n; i++) begin
      chk("R6 dout_oe during read", 32'(dout_oe), 32'd1);
      if (i < 16) w[i] = dout;
      else chk("R6 read wrap bit", 32'(dout), 32'(w[i-16]));
      sk = 1'b1; step();
      sk = 1'b0; step();
    end
    finish_xfer();
    chk("R10 dout_oe after ce low", 32'(dout_oe), 32'd0);
  endtask

  initial begin
    #(CLK_P * 150000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [15:0] w;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    chk("R1 dout_oe after reset", 32'(dout_oe), 32'd0);
    read_word(0, 4'd0, 3'b110, 16, w);  chk("R1 word 0 zero", 32'(w), 32'h0);
    read_word(0, 4'd15, 3'b110, 16, w); chk("R1 word 15 zero", 32'(w), 32'h0);

    write_word(0, 4'd5, 32'hA5A5, 16);
    read_word(0, 4'd5, 3'b110, 16, w);  chk("R4 write without latch", 32'(w), 32'h0);

    one_byte(0, 3, 3'b100);  // R2 leading zeros before set-enable
    write_word(0, 4'd5, 32'hA5A5, 16);
    read_word(0, 4'd5, 3'b110, 16, w);  chk("R2 R5 word 5 written", 32'(w), 32'hA5A5);

    write_word(0, 4'd7, 32'hF1234, 20);
    read_word(0, 4'd7, 3'b110, 18, w);  chk("R5 pointer wrap overwrite", 32'(w), 32'h123F);
    read_word(0, 4'd7, 3'b111, 16, w);  chk("R3 read code 111", 32'(w), 32'h123F);

    one_byte(0, 0, 3'b001);
    write_word(0, 4'd5, 32'h0, 16);
    read_word(0, 4'd5, 3'b110, 16, w);  chk("R7 ram cleared before recall", 32'(w), 32'h0);
    one_byte(0, 0, 3'b101);
    read_word(0, 4'd5, 3'b110, 16, w);  chk("R7 recall word 5", 32'(w), 32'hA5A5);
    read_word(0, 4'd7, 3'b110, 16, w);  chk("R7 recall word 7", 32'(w), 32'h123F);

    one_byte(0, 0, 3'b000);
    write_word(0, 4'd5, 32'h1111, 16);
    read_word(0, 4'd5, 3'b110, 16, w);  chk("R4 write after clear", 32'(w), 32'hA5A5);

    one_byte(0, 0, 3'b100);
    write_word(0, 4'd5, 32'h1111, 16);
    one_byte(0, 0, 3'b000);
    one_byte(0, 0, 3'b001);
    one_byte(0, 0, 3'b101);
    read_word(0, 4'd5, 3'b110, 16, w);  chk("R4 store gated by latch", 32'(w), 32'hA5A5);

    one_byte(0, 0, 3'b100);
    instr(0, 0, 4'd5, 3'b010);
    for (int i = 0; i < 16; i++) send_bit(1'b0);
    finish_xfer();
    read_word(0, 4'd5, 3'b110, 16, w);  chk("R8 R11 reserved plus extra clocks", 32'(w), 32'hA5A5);
    write_word(0, 4'd6, 32'h00C3, 16);
    read_word(0, 4'd6, 3'b110, 16, w);  chk("R8 latch kept through reserved", 32'(w), 32'h00C3);

    one_byte(1, 0, 3'b000);
    write_word(0, 4'd3, 32'hBEEF, 16);
    read_word(0, 4'd3, 3'b110, 16, w);  chk("R9 ce-start clear latch", 32'(w), 32'h0);
    one_byte(1, 0, 3'b100);
    write_word(1, 4'd3, 32'hBEEF, 16);
    read_word(1, 4'd3, 3'b110, 16, w);  chk("R9 ce-start write and read", 32'(w), 32'hBEEF);

    write_word(0, 4'd9, 32'h000A, 4);
    read_word(0, 4'd9, 3'b110, 16, w);  chk("R10 partial write then ce low", 32'(w), 32'h000A);
    read_word(0, 4'd3, 3'b110, 4, w);   chk("R10 partial read", 32'(w[3:0]), 32'hF);
    read_word(0, 4'd3, 3'b110, 16, w);  chk("R10 decoder reset after abort", 32'(w), 32'hBEEF);

    step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule